// File: doc/BRIEF.md
# Mixed-Latency Floating-Point Execute Cluster

This block is the execute stage of an in-order pipeline that keeps its floating-point units apart from the integer path. It contains a one-cycle integer path (also used for load/store address generation), a two-stage pipelined adder, a four-stage pipelined multiplier and a divider that is not pipelined. Every operation is a token that carries a destination register number and an ID. No arithmetic is performed. The cluster tracks only how long each unit holds a token and which unit can accept one.

Decode offers at most one token per cycle and names the target unit with an opcode. The cluster reports, combinationally, whether each unit can take a token. It raises a stall when the offered token's unit cannot accept it, and decode then holds the token. Each unit has its own completion port. That port shows a finished token for one cycle, together with the number of cycles the token spent in the unit.

Top module: `fpx_cluster`

## Requirements
- R1: Opcode 0 selects the integer path. A token accepted at clock edge E appears on completion port 0 right after edge E, with latency field 1.
- R2: Opcode 1 selects the adder. A token accepted at edge E appears on port 1 right after edge E+1, with latency field 2. The adder accepts a token every cycle.
- R3: Opcode 2 selects the multiplier. A token accepted at edge E appears on port 2 right after edge E+3, with latency field 4. The multiplier accepts a token every cycle.
- R4: Opcode 3 selects the divider. A token accepted at edge E appears on port 3 right after edge E+4, with latency field 5. Divider ready (bit 3) is low from edge E until the token's completion cycle. Ready returns high in that completion cycle, so the next divide can be accepted at edge E+5.
- R5: `stall` is high exactly when `inValid` is high and the ready bit of the unit named by `inOp` is low. A stalled token is not accepted and produces no completion.
- R6: Each accepted token makes its unit's `outValid` bit high for exactly one cycle. In that cycle the unit's slice of `outDest` and `outId` carries the values the token was offered with.
- R7: A synchronous active-high `rst` clears all completion valids and frees the divider, so that all four ready bits are high after reset. A divide in flight at reset never completes.
- R8: Ready bits 0, 1 and 2 are always high, and a token goes only to the unit its opcode names.
- R9: While `inValid` is low nothing is accepted, whatever the opcode. In particular, divider ready stays high and no completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Decode offers a token this cycle |
| inOp | input | 2 | Target unit: 0 integer, 1 add, 2 multiply, 3 divide |
| inDest | input | DEST_W | Destination register of the offered token |
| inId | input | ID_W | Tag of the offered token |
| stall | output | 1 | Offered token cannot be accepted; decode must hold it |
| unitReady | output | 4 | Per-unit ready, bit index equals opcode |
| outValid | output | 4 | Per-unit completion strobe, bit index equals opcode |
| outDest | output | 4*DEST_W | Completed destination, unit u in slice u |
| outId | output | 4*ID_W | Completed tag, unit u in slice u |
| outLat | output | 4*LAT_W | Cycles the completed token spent in its unit |

## Verification
The assertions assume that `inOp` and `inValid` are known at every sampled edge, and that the parameterised latencies are at least 2 for the divider and at least 1 for the pipelines. The random stimulus draws every opcode with `inValid` high about three cycles in four. Divides therefore often arrive while the divider is busy, which exercises the stall path, and drawing opcode 3 with `inValid` low tests that an invalid slot leaves the divider alone. Directed cases add a back-to-back divide pair spaced by the divider's own readiness and a reset taken while a divide is in flight.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  parameter int DEST_W    = 5;
  parameter int ID_W      = 6;
  parameter int LAT_W     = 4;
  parameter int NUM_UNITS = 4;

  localparam logic [1:0] OP_INT = 2'd0;
  localparam logic [1:0] OP_ADD = 2'd1;
  localparam logic [1:0] OP_MUL = 2'd2;
  localparam logic [1:0] OP_DIV = 2'd3;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [ID_W-1:0]   id;
    logic [LAT_W-1:0]  age;
  } token_t;

  typedef struct packed {
    logic [NUM_UNITS-1:0] fire;
    logic                 divAdvance;
    logic                 divFinish;
  } strobes_t;
endpackage

// File: rtl/fpx_pipe.sv
module fpx_pipe
  import fpx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   fire,
  input  token_t inTok,
  output logic   outValid,
  output token_t outTok
);
  logic [DEPTH-1:0] stgValid;
  token_t           stgTok [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      stgValid <= '0;
    end else begin
      stgValid[0] <= fire;
      for (int k = 1; k < DEPTH; k++) begin
        stgValid[k] <= stgValid[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    stgTok[0]     <= inTok;
    stgTok[0].age <= LAT_W'(1);
    for (int k = 1; k < DEPTH; k++) begin
      stgTok[k]     <= stgTok[k-1];
      stgTok[k].age <= stgTok[k-1].age + LAT_W'(1);
    end
  end

  assign outValid = stgValid[DEPTH-1];
  assign outTok   = stgTok[DEPTH-1];

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_chk
      // R6: a stage is occupied only when its predecessor held the same token
      a_r6_stage_follow: assert property (@(posedge clk) disable iff (rst)
        stgValid[k] |-> ($past(stgValid[k-1]) && stgTok[k].id == $past(stgTok[k-1].id)));
    end
  endgenerate

  // R2/R3: a token leaving the pipe has spent DEPTH cycles inside
  a_r3_exit_age: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outTok.age == LAT_W'(DEPTH)));
endmodule

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
#(
  parameter int DIV_LAT = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [1:0]           inOp,
  output strobes_t             strb,
  output logic [NUM_UNITS-1:0] unitReady,
  output logic                 stall
);
  localparam int CNT_W = $clog2(DIV_LAT + 1);

  logic             divBusy;
  logic [CNT_W-1:0] divCnt;
  logic             divLast;
  logic             divReady;

  assign divLast   = divBusy && (divCnt == '0);
  assign divReady  = !divBusy || divLast;
  assign unitReady = {divReady, 1'b1, 1'b1, 1'b1};
  assign stall     = inValid && !unitReady[inOp];

  always_comb begin
    strb            = '0;
    strb.divAdvance = divBusy && !divLast;
    strb.divFinish  = divLast;
    if (inValid && unitReady[inOp] && !rst) begin
      strb.fire[inOp] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divBusy <= 1'b0;
      divCnt  <= '0;
    end else if (strb.fire[OP_DIV]) begin
      divBusy <= 1'b1;
      divCnt  <= CNT_W'(DIV_LAT - 1);
    end else if (divBusy) begin
      if (divLast) divBusy <= 1'b0;
      else         divCnt  <= divCnt - CNT_W'(1);
    end
  end

  // R8: at most one unit receives a token per cycle
  a_r8_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.fire));
  // R4: a divide just taken leaves the divider unavailable
  a_r4_div_blocks: assert property (@(posedge clk) disable iff (rst)
    strb.fire[OP_DIV] |=> !unitReady[OP_DIV]);
  // R5: a stalled cycle accepts nothing
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    stall |-> (strb.fire == '0));
  // R6: a divide completion lasts a single cycle
  a_r6_div_single: assert property (@(posedge clk) disable iff (rst)
    strb.divFinish |=> !strb.divFinish);
  // R9: an empty slot leaves a free divider free
  a_r9_idle_free: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !divBusy) |=> unitReady[OP_DIV]);
endmodule

// File: rtl/fpx_datapath.sv
module fpx_datapath
  import fpx_pkg::*;
#(
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobes_t                   strb,
  input  logic [DEST_W-1:0]          inDest,
  input  logic [ID_W-1:0]            inId,
  output logic [NUM_UNITS-1:0]       outValid,
  output logic [NUM_UNITS*DEST_W-1:0] outDest,
  output logic [NUM_UNITS*ID_W-1:0]  outId,
  output logic [NUM_UNITS*LAT_W-1:0] outLat
);
  token_t inTok;
  token_t doneTok [NUM_UNITS];
  token_t divTok;

  always_comb begin
    inTok.dest = inDest;
    inTok.id   = inId;
    inTok.age  = LAT_W'(1);
  end

  generate
    for (genvar u = 0; u < NUM_UNITS - 1; u++) begin : g_pipe
      localparam int DEPTH = (u == 0) ? 1 : ((u == 1) ? ADD_LAT : MUL_LAT);
      fpx_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .fire     (strb.fire[u]),
        .inTok    (inTok),
        .outValid (outValid[u]),
        .outTok   (doneTok[u])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.fire[NUM_UNITS-1]) begin
      divTok <= inTok;
    end else if (strb.divAdvance) begin
      divTok.age <= divTok.age + LAT_W'(1);
    end
  end

  assign outValid[NUM_UNITS-1] = strb.divFinish;
  assign doneTok[NUM_UNITS-1]  = divTok;

  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_out
      assign outDest[u*DEST_W +: DEST_W] = doneTok[u].dest;
      assign outId[u*ID_W +: ID_W]       = doneTok[u].id;
      assign outLat[u*LAT_W +: LAT_W]    = doneTok[u].age;
    end
  endgenerate

  // R6: the divider token is frozen while it waits to complete
  a_r6_div_tag_held: assert property (@(posedge clk) disable iff (rst)
    strb.divAdvance |=> $stable(divTok.id) && $stable(divTok.dest));
  // R1: the integer path completes exactly one cycle after it is fed
  a_r1_int_one_cycle: assert property (@(posedge clk) disable iff (rst)
    strb.fire[0] |=> outValid[0]);
endmodule

// File: rtl/fpx_cluster.sv
module fpx_cluster
  import fpx_pkg::*;
#(
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 4,
  parameter int DIV_LAT = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic [1:0]                  inOp,
  input  logic [DEST_W-1:0]           inDest,
  input  logic [ID_W-1:0]             inId,
  output logic                        stall,
  output logic [NUM_UNITS-1:0]        unitReady,
  output logic [NUM_UNITS-1:0]        outValid,
  output logic [NUM_UNITS*DEST_W-1:0] outDest,
  output logic [NUM_UNITS*ID_W-1:0]   outId,
  output logic [NUM_UNITS*LAT_W-1:0]  outLat
);
  strobes_t strb;

  fpx_ctrl #(.DIV_LAT(DIV_LAT)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inOp      (inOp),
    .strb      (strb),
    .unitReady (unitReady),
    .stall     (stall)
  );

  fpx_datapath #(.ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inDest   (inDest),
    .inId     (inId),
    .outValid (outValid),
    .outDest  (outDest),
    .outId    (outId),
    .outLat   (outLat)
  );
endmodule

// File: tb/fpx_cluster_tb.sv
`timescale 1ns/1ps
module fpx_cluster_tb;
  import fpx_pkg::*;

  logic                        clk = 1'b0;
  logic                        rst;
  logic                        inValid;
  logic [1:0]                  inOp;
  logic [DEST_W-1:0]           inDest;
  logic [ID_W-1:0]             inId;
  logic                        stall;
  logic [NUM_UNITS-1:0]        unitReady;
  logic [NUM_UNITS-1:0]        outValid;
  logic [NUM_UNITS*DEST_W-1:0] outDest;
  logic [NUM_UNITS*ID_W-1:0]   outId;
  logic [NUM_UNITS*LAT_W-1:0]  outLat;

  fpx_cluster u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp), .inDest(inDest),
    .inId(inId), .stall(stall), .unitReady(unitReady), .outValid(outValid),
    .outDest(outDest), .outId(outId), .outLat(outLat)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int divNextOk = 0;
  bit finished = 0;
  bit              expV    [NUM_UNITS][16];
  logic [ID_W-1:0]   expId   [NUM_UNITS][16];
  logic [DEST_W-1:0] expDest [NUM_UNITS][16];

  function automatic int unitLat(int u);
    case (u)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic bit divFree(int c);
    return (c + 1) >= divNextOk;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clearModel();
    for (int u = 0; u < NUM_UNITS; u++)
      for (int s = 0; s < 16; s++) expV[u][s] = 1'b0;
    divNextOk = 0;
  endtask

  task automatic checkOutputs();
    for (int u = 0; u < NUM_UNITS; u++) begin
      int s = cyc % 16;
      string req;
      req = (u == 0) ? "R1" : (u == 1) ? "R2" : (u == 2) ? "R3" : "R4";
      check(outValid[u] == expV[u][s], "R6 valid", int'(outValid[u]), int'(expV[u][s]));
      if (expV[u][s] && outValid[u]) begin
        check(outId[u*ID_W +: ID_W] == expId[u][s], "R6 id",
              int'(outId[u*ID_W +: ID_W]), int'(expId[u][s]));
        check(outDest[u*DEST_W +: DEST_W] == expDest[u][s], "R6 dest",
              int'(outDest[u*DEST_W +: DEST_W]), int'(expDest[u][s]));
        check(int'(outLat[u*LAT_W +: LAT_W]) == unitLat(u), req,
              int'(outLat[u*LAT_W +: LAT_W]), unitLat(u));
      end
      expV[u][s] = 1'b0;
    end
  endtask

  // Drive one slot at a negedge, check stall/ready, advance one cycle, check outputs
  task automatic step(bit v, logic [1:0] op, logic [DEST_W-1:0] d, logic [ID_W-1:0] id);
    bit expReady;
    bit expStall;
    inValid = v; inOp = op; inDest = d; inId = id;
    #1;
    expReady = divFree(cyc);
    check(unitReady[2:0] == 3'b111, "R8 ready", int'(unitReady[2:0]), 7);
    check(unitReady[3] == expReady, "R4 div ready", int'(unitReady[3]), int'(expReady));
    expStall = v && (op == OP_DIV) && !expReady;
    check(stall == expStall, "R5 stall", int'(stall), int'(expStall));
    if (v && !expStall) begin
      int s = (cyc + unitLat(int'(op))) % 16;
      expV[op][s] = 1'b1;
      expId[op][s] = id;
      expDest[op][s] = d;
      if (op == OP_DIV) divNextOk = cyc + 1 + 5;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    checkOutputs();
  endtask

  task automatic doReset(bit busyIn);
    rst = 1'b1;
    inValid = busyIn; inOp = OP_DIV; inDest = '0; inId = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    cyc += 2;
    clearModel();
    #1;
    check(outValid == '0, "R7 valids", int'(outValid), 0);
    check(unitReady == 4'hF, "R7 ready", int'(unitReady), 15);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [ID_W-1:0] tag = '0;
    void'($urandom(32'd4711));
    rst = 1'b1; inValid = 1'b0; inOp = '0; inDest = '0; inId = '0;
    clearModel();
    @(negedge clk);
    doReset(1'b1);

    // R1/R2/R3: one token to each pipelined unit, then an adder and multiplier burst
    step(1, OP_INT, 5'd1, 6'd1);
    step(1, OP_ADD, 5'd2, 6'd2);
    step(1, OP_MUL, 5'd3, 6'd3);
    for (int i = 0; i < 4; i++) step(1, OP_ADD, 5'(10 + i), 6'(10 + i));
    for (int i = 0; i < 5; i++) step(1, OP_MUL, 5'(20 + i), 6'(20 + i));
    for (int i = 0; i < 6; i++) step(0, OP_INT, '0, '0);

    // R4: back-to-back divides; the offer repeats while stalled (R5)
    step(1, OP_DIV, 5'd7, 6'd40);
    for (int i = 0; i < 4; i++) step(1, OP_DIV, 5'd8, 6'd41);
    step(1, OP_DIV, 5'd8, 6'd41);
    for (int i = 0; i < 8; i++) step(0, OP_INT, '0, '0);

    // R9: opcode 3 with inValid low leaves the divider idle
    for (int i = 0; i < 4; i++) step(0, OP_DIV, 5'd9, 6'd50);

    // R7: reset while a divide is in flight
    step(1, OP_DIV, 5'd11, 6'd51);
    step(0, OP_INT, '0, '0);
    doReset(1'b1);
    for (int i = 0; i < 8; i++) step(0, OP_INT, '0, '0);

    // Random mix, including stalled divides
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      logic [1:0] op = 2'($urandom % 4);
      tag = tag + 1'b1;
      step(v, op, DEST_W'($urandom), tag);
    end
    for (int i = 0; i < 8; i++) step(0, OP_INT, '0, '0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule